// File: doc/BRIEF.md
# Lens-driver serial control target

This block is the serial control port of a small lens and shutter driver. It listens on a two-wire bus as a 7-bit-address target and acknowledges the fixed address `0110010`. A write frame has three bytes: the address byte, a register-address byte and a data byte. Each write updates one entry of a four-entry control register file. The decoded fields go straight to the focus-motor sequencer and to the shutter bridge. A read frame returns the hold/sequence register, with the sequencer's live busy state in the most significant bit.

The two bus lines are first brought into the system clock domain through a two-stage synchroniser, and bus events are found on those synchronised copies. A single enumerated link state machine does the work. Its states are `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_REG`, `ST_REG_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_RD_BYTE`, `ST_RD_ACK` and `ST_WAIT`. The transitions are:
- From any state, START goes to `ST_ADDR` and STOP goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches and to `ST_WAIT` when it does not.
- After `ST_ADDR_ACK`, a write continues in `ST_REG`, then `ST_REG_ACK`, then `ST_DATA`, then `ST_DATA_ACK`, then back to `ST_DATA` for any further data byte.
- After `ST_ADDR_ACK`, a read goes to `ST_RD_BYTE`, then `ST_RD_ACK`. From `ST_RD_ACK` it returns to `ST_RD_BYTE` on a controller ACK and goes to `ST_WAIT` on a NACK.

Each move out of a byte or acknowledge state happens on a falling SCL edge. A write whose data has bit 1 set, sent to the focus register, arms a one-cycle sequence-start pulse. That pulse fires after the next STOP.

Top module: `lensdrv_i2c_target`

## Requirements
- R1: The block pulls SDA low during the ninth clock of a byte only in these cases: an address byte `0110010` followed by any R/W bit, and every register-address and data byte of a write it has acknowledged. For any other address it never pulls SDA low, and it ignores every byte until the next START.
- R2: START (SDA falls while SCL is high) begins a new frame from any state, including a repeated START in the middle of a frame. STOP (SDA rises while SCL is high) ends the frame.
- R3: A write stores the data byte into the register selected by the register-address byte. The focus register `0x00` keeps all 8 bits. The hold register `0x01` keeps bits 6:0; bit 7 is read-only. The shutter register `0x81` keeps bits 2:0. The current register `0x03` keeps bits 3:0. Register outputs change only after a data byte.
- R4: A write to address `0x07`, or to any address other than the four mapped ones, leaves every output unchanged.
- R5: Each shutter pin reports `00` for high impedance, `01` for driven low and `10` for driven high. While shutter bit 2 is 0, both pins are `00`. With bit 2 set, bits 1:0 select the pin states (pin A, pin B): `00` gives (`00`,`00`), `01` gives (`10`,`01`), `10` gives (`01`,`10`) and `11` gives (`01`,`01`). Both pins are never driven high at once.
- R6: `current_code_o` equals bits 3:0 of the last data written to `0x03`. Code 0 means the highest current, and each step up lowers it by one 10 mA step.
- R7: A read returns, MSB first, `{busy_i, hold bits 6:0}`. The value is sampled when each byte starts. A controller ACK makes the block send the byte again; a NACK releases the bus until the next START.
- R8: `seq_start_o` pulses high for exactly one cycle after the STOP that ends a frame containing a write to `0x00` with data bit 1 set. It never pulses otherwise.
- R9: The SDA pull-low output changes only while the synchronised SCL is low. It is released after the falling edge of the ninth clock.
- R10: After reset, every register output is zero, both shutter pins are `00`, and SDA is not pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| busy_i | input | 1 | Live busy state from the focus sequencer |
| sda_pull_o | output | 1 | When 1, the open-drain pad pulls SDA low |
| focus_mode_o | output | 8 | Focus register `0x00` |
| hold_cfg_o | output | 7 | Hold/sequence register `0x01`, bits 6:0 |
| current_code_o | output | 4 | Current code from register `0x03` |
| pin_a_o | output | 2 | Shutter pin A state (`00` Z, `01` low, `10` high) |
| pin_b_o | output | 2 | Shutter pin B state (`00` Z, `01` low, `10` high) |
| seq_start_o | output | 1 | One-cycle sequence launch pulse |

## Verification
A bus edge reaches the state machine three clocks after it changes at the pin: two synchroniser stages plus one edge-compare register. The pull-low output therefore follows an SCL falling edge by three to four clocks. A register output updates one clock after the data byte's acknowledge state is entered. The sequence pulse appears four clocks after SDA rises in a STOP. The bench changes a line only on a falling clock edge and then waits a quarter bus period of eight clocks before the next change or sample, so every result is already settled when it is read. The scoreboard compares register outputs six clocks after each frame's STOP.

// File: rtl/lensdrv_i2c_pkg.sv
package lensdrv_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } link_state_t;

    localparam logic [1:0] PIN_Z  = 2'b00;
    localparam logic [1:0] PIN_LO = 2'b01;
    localparam logic [1:0] PIN_HI = 2'b10;

    localparam logic [7:0] RA_FOCUS   = 8'h00;
    localparam logic [7:0] RA_HOLD    = 8'h01;
    localparam logic [7:0] RA_CURRENT = 8'h03;
    localparam logic [7:0] RA_SHUTTER = 8'h81;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
            scl_q     <= scl_chain[SYNC_STAGES-1];
            sda_q     <= sda_chain[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_chain[SYNC_STAGES-1];
    assign sda_s     = sda_chain[SYNC_STAGES-1];
    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import lensdrv_i2c_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ADDR = 7'b0110010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    link_state_t       state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              rw;
    logic              master_nack;

    wire byte_done = scl_fall && (cnt == CNT_FULL);

    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: state_nx = state;
                ST_ADDR: if (byte_done)
                    state_nx = (shreg[BYTE_W-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK: if (scl_fall)
                    state_nx = rw ? ST_RD_BYTE : ST_REG;
                ST_REG:      if (byte_done) state_nx = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall)  state_nx = ST_DATA;
                ST_DATA:     if (byte_done) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_nx = ST_DATA;
                ST_RD_BYTE:  if (scl_fall && cnt == CNT_LAST) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                    state_nx = master_nack ? ST_WAIT : ST_RD_BYTE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            txreg       <= '0;
            rw          <= 1'b0;
            master_nack <= 1'b1;
            wr_stb      <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            state  <= state_nx;
            wr_stb <= 1'b0;
            if (start_det || stop_det) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_REG, ST_DATA: begin
                        if (scl_rise && cnt < CNT_FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_ADDR) rw <= shreg[0];
                            if (state == ST_REG)  wr_addr <= shreg;
                            if (state == ST_DATA) begin
                                wr_stb  <= 1'b1;
                                wr_data <= shreg;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            txreg <= rd_data;
                            cnt   <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            txreg <= {txreg[BYTE_W-2:0], 1'b1};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) master_nack <= sda_s;
                        if (scl_fall) begin
                            txreg <= rd_data;
                            cnt   <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_REG_ACK, ST_DATA_ACK: sda_pull = 1'b1;
            ST_RD_BYTE:                           sda_pull = ~txreg[BYTE_W-1];
            default:                              sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/lensdrv_regfile.sv
module lensdrv_regfile
    import lensdrv_i2c_pkg::*;
#(
    parameter int HOLD_W = 7,
    parameter int CUR_W  = 4,
    parameter int BRG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              stop_det,
    input  logic              busy_i,
    output logic [BYTE_W-1:0] focus_mode,
    output logic [HOLD_W-1:0] hold_cfg,
    output logic [CUR_W-1:0]  current_code,
    output logic [BRG_W-1:0]  bridge_cfg,
    output logic [BYTE_W-1:0] rd_data,
    output logic              seq_start
);

    localparam int LAUNCH_BIT = 1;

    logic seq_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            focus_mode   <= '0;
            hold_cfg     <= '0;
            current_code <= '0;
            bridge_cfg   <= '0;
            seq_pend     <= 1'b0;
            seq_start    <= 1'b0;
        end else begin
            seq_start <= 1'b0;
            if (wr_stb) begin
                unique case (wr_addr)
                    RA_FOCUS: begin
                        focus_mode <= wr_data;
                        if (wr_data[LAUNCH_BIT]) seq_pend <= 1'b1;
                    end
                    RA_HOLD:    hold_cfg     <= wr_data[HOLD_W-1:0];
                    RA_CURRENT: current_code <= wr_data[CUR_W-1:0];
                    RA_SHUTTER: bridge_cfg   <= wr_data[BRG_W-1:0];
                    default: ;
                endcase
            end else if (stop_det && seq_pend) begin
                seq_start <= 1'b1;
                seq_pend  <= 1'b0;
            end
        end
    end

    assign rd_data = {busy_i, hold_cfg};

endmodule

// File: rtl/shutter_bridge_dec.sv
module shutter_bridge_dec
    import lensdrv_i2c_pkg::*;
(
    input  logic [2:0] bridge_cfg,
    output logic [1:0] pin_a,
    output logic [1:0] pin_b
);

    always_comb begin
        pin_a = PIN_Z;
        pin_b = PIN_Z;
        if (bridge_cfg[2]) begin
            unique case (bridge_cfg[1:0])
                2'b00: begin pin_a = PIN_Z;  pin_b = PIN_Z;  end
                2'b01: begin pin_a = PIN_HI; pin_b = PIN_LO; end
                2'b10: begin pin_a = PIN_LO; pin_b = PIN_HI; end
                default: begin pin_a = PIN_LO; pin_b = PIN_LO; end
            endcase
        end
    end

endmodule

// File: rtl/lensdrv_i2c_target.sv
module lensdrv_i2c_target
    import lensdrv_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0110010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       busy_i,
    output logic       sda_pull_o,
    output logic [7:0] focus_mode_o,
    output logic [6:0] hold_cfg_o,
    output logic [3:0] current_code_o,
    output logic [1:0] pin_a_o,
    output logic [1:0] pin_b_o,
    output logic       seq_start_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_data;
    logic [2:0]        bridge_cfg;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull_o),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    lensdrv_regfile u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .stop_det     (stop_det),
        .busy_i       (busy_i),
        .focus_mode   (focus_mode_o),
        .hold_cfg     (hold_cfg_o),
        .current_code (current_code_o),
        .bridge_cfg   (bridge_cfg),
        .rd_data      (rd_data),
        .seq_start    (seq_start_o)
    );

    shutter_bridge_dec u_bridge (
        .bridge_cfg (bridge_cfg),
        .pin_a      (pin_a_o),
        .pin_b      (pin_b_o)
    );

endmodule

// File: rtl/lensdrv_i2c_chk.sv
module lensdrv_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull,
    input logic       scl_sync,
    input logic       stop_det,
    input logic       wr_stb,
    input logic       seq_start,
    input logic [7:0] focus,
    input logic [6:0] hold,
    input logic [3:0] cur,
    input logic [1:0] pin_a,
    input logic [1:0] pin_b
);

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_pull) |-> !scl_sync); // R9
    AST_SEQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) seq_start |=> !seq_start); // R8
    AST_SEQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n) seq_start |-> $past(stop_det)); // R8
    AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !$past(wr_stb) |-> ($stable(focus) && $stable(hold) && $stable(cur))); // R3
    AST_NO_DOUBLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !(pin_a == 2'b10 && pin_b == 2'b10)); // R5

endmodule

bind lensdrv_i2c_target lensdrv_i2c_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_pull  (sda_pull_o),
    .scl_sync  (scl_s),
    .stop_det  (stop_det),
    .wr_stb    (wr_stb),
    .seq_start (seq_start_o),
    .focus     (focus_mode_o),
    .hold      (hold_cfg_o),
    .cur       (current_code_o),
    .pin_a     (pin_a_o),
    .pin_b     (pin_b_o)
);

// File: tb/tb_lensdrv_i2c_target.sv
module tb_lensdrv_i2c_target;

    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h64;
    localparam logic [7:0] AR = 8'h65;

    typedef struct packed {
        logic [7:0] focus;
        logic [6:0] hold;
        logic [3:0] cur;
        logic [1:0] pa;
        logic [1:0] pb;
        logic [7:0] seqs;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_pull_o, seq_start_o;
    logic [7:0] focus_mode_o;
    logic [6:0] hold_cfg_o;
    logic [3:0] current_code_o;
    logic [1:0] pin_a_o, pin_b_o;
    wire  sda_line = sda_m & ~sda_pull_o;

    int checks = 0;
    int errors = 0;
    int seq_seen = 0;
    bit done = 1'b0;

    snap_t exp_q[$];
    string tag_q[$];
    snap_t model;

    always #5 clk = ~clk;

    lensdrv_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .busy_i(busy),
        .sda_pull_o(sda_pull_o), .focus_mode_o(focus_mode_o), .hold_cfg_o(hold_cfg_o),
        .current_code_o(current_code_o), .pin_a_o(pin_a_o), .pin_b_o(pin_b_o),
        .seq_start_o(seq_start_o)
    );

    always @(negedge clk) if (rst_n && seq_start_o) seq_seen++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = (sda_line == 1'b0);
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_line;
            wq();
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic void apply_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h00: begin model.focus = d; if (d[1]) model.seqs++; end
            8'h01: model.hold = d[6:0];
            8'h03: model.cur = d[3:0];
            8'h81: begin
                model.pa = 2'b00; model.pb = 2'b00;
                if (d[2]) case (d[1:0])
                    2'b01: begin model.pa = 2'b10; model.pb = 2'b01; end
                    2'b10: begin model.pa = 2'b01; model.pb = 2'b10; end
                    2'b11: begin model.pa = 2'b01; model.pb = 2'b01; end
                    default: ;
                endcase
            end
            default: ;
        endcase
    endfunction

    task automatic push_exp(input string tag);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        repeat (20) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input string tag);
        logic ak;
        bus_start();
        send_byte(AW, ak); chk("R1 address ack", ak, 1'b1);
        send_byte(a, ak);  chk("R1 register ack", ak, 1'b1);
        send_byte(d, ak);  chk("R1 data ack", ak, 1'b1);
        chk("R9 released after ninth clock", sda_pull_o, 1'b0);
        bus_stop();
        apply_write(a, d);
        push_exp(tag);
    endtask

    initial begin : monitor
        snap_t e, a;
        string t;
        forever begin
            wait (exp_q.size() != 0);
            repeat (6) @(negedge clk);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{focus: focus_mode_o, hold: hold_cfg_o, cur: current_code_o,
                  pa: pin_a_o, pb: pin_b_o, seqs: 8'(seq_seen)};
            chk(t, a, e);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic ak;
        logic [7:0] rb;
        model = '0;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 reset outputs", {focus_mode_o, hold_cfg_o, current_code_o, pin_a_o, pin_b_o, sda_pull_o, seq_start_o}, '0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        reg_write(8'h00, 8'hA5, "R3 focus write, R8 no launch");
        reg_write(8'h00, 8'h03, "R8 launch pulse after stop");
        reg_write(8'h01, 8'hFF, "R3 hold bit7 read-only");
        reg_write(8'h03, 8'hF9, "R6 current code low nibble");
        reg_write(8'h81, 8'h05, "R5 pin A high B low");
        reg_write(8'h81, 8'h06, "R5 pin A low B high");
        reg_write(8'h81, 8'h07, "R5 brake both low");
        reg_write(8'h81, 8'h03, "R5 disabled bridge high-Z");
        reg_write(8'h81, 8'h04, "R5 enabled mode 00 high-Z");
        reg_write(8'h07, 8'hFF, "R4 test address ignored");
        reg_write(8'h02, 8'h55, "R4 unmapped 0x02 ignored");
        reg_write(8'h80, 8'hFF, "R4 unmapped 0x80 ignored");

        // R1 foreign address: no ack, following bytes ignored
        bus_start();
        send_byte(8'h66, ak); chk("R1 foreign address nack", ak, 1'b0);
        send_byte(8'h00, ak); chk("R1 no ack after foreign address", ak, 1'b0);
        send_byte(8'h13, ak);
        bus_stop();
        push_exp("R1 foreign frame changes nothing");

        // R2 repeated start mid-frame restarts decoding
        bus_start();
        send_byte(AW, ak);
        send_byte(8'h00, ak);
        bus_start();
        send_byte(AW, ak);    chk("R2 address ack after repeated start", ak, 1'b1);
        send_byte(8'h03, ak);
        send_byte(8'h0A, ak);
        bus_stop();
        apply_write(8'h03, 8'h0A);
        push_exp("R2 repeated start write");

        // R7 read: busy high, ack then nack
        busy = 1'b1;
        bus_start();
        send_byte(AR, ak); chk("R1 read address ack", ak, 1'b1);
        recv_byte(1'b1, rb); chk("R7 read with busy set", rb, 8'hFF);
        recv_byte(1'b0, rb); chk("R7 repeated byte after ack", rb, 8'hFF);
        bus_stop();
        busy = 1'b0;
        reg_write(8'h01, 8'h2C, "R3 hold rewrite");
        bus_start();
        send_byte(AR, ak);
        recv_byte(1'b0, rb); chk("R7 read with busy clear", rb, 8'h2C);
        bus_stop();
        push_exp("R7 read leaves state unchanged");

        wait (exp_q.size() == 0);
        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule